// File: doc/BRIEF.md
# Ascending Letter Pair Detector

This block watches a stream of letters, one letter per clock cycle when a strobe marks it valid. Each letter arrives as a two-bit code. The block raises its output in the same cycle as a letter that follows its predecessor directly in alphabetic order. With four letters the only such pairs are A then B, B then C, and C then D.

The block keeps two pieces of state: the last valid letter and a flag showing that such a letter exists. It works out the output from that stored letter and the letter now on the input. The output is therefore a combinational (Mealy) function of the state and the current input. Cycles without the strobe leave the state alone and keep the output low. Several detectors can share one letter stream, each fed by its own strobe.

Top module: `letter_step_detect`

## Requirements
- R1: The first valid letter after reset never raises `hit`, because no earlier letter is stored.
- R2: Letters are coded A=2'b00, B=2'b01, C=2'b10, D=2'b11. In a valid cycle `hit` is 1 when the stored letter and `sym_in` form A→B, B→C or C→D. The output is combinational, so it shows in the same cycle as the second letter.
- R3: D followed by A does not wrap around and gives `hit`=0.
- R4: A letter repeated in consecutive valid cycles (AA, BB, CC, DD) gives `hit`=0.
- R5: Descending pairs and non-adjacent ascending pairs (such as B→A or A→C) give `hit`=0.
- R6: With `sym_valid` low, `hit` is 0 and the stored letter is kept. The next valid letter is judged against the last valid letter, whatever `sym_in` carried in between.
- R7: Every valid letter replaces the stored letter, so overlapping runs such as A,B,C,D give `hit` on B, C and D.
- R8: The synchronous reset `rst` wins over a valid letter in the same cycle. `hit` is 0 while `rst` is high, and the stored letter and flag are cleared, so the first valid letter after reset acts as in R1.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid | input | 1 | Marks `sym_in` as a letter for this cycle |
| sym_in | input | 2 | Letter code, A=00 B=01 C=10 D=11 |
| hit | output | 1 | High when the current letter directly follows the stored one |

## Verification
Two events can fall in the same cycle: a reset, and a valid letter that would otherwise complete an ascending pair. The bench provokes this by driving `rst` high together with a B that follows a stored A. It expects `hit` low in that cycle. It then expects a following C to be treated as a first letter and give no hit. A behavioural model in the bench predicts `hit` every cycle over directed and pseudo-random streams, so this overlap is also judged whenever random resets land on valid letters.

// File: rtl/ltr_pkg.sv
package ltr_pkg;
    localparam int SYM_W = 2;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        sym_t prev;
        logic have;
    } hist_t;
endpackage

// File: rtl/ltr_hist.sv
module ltr_hist
    import ltr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  sym_t sym,
    output sym_t prev,
    output logic have
);
    hist_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.prev = '0;
            st_d.have = 1'b0;
        end else if (load) begin
            st_d.prev = sym;
            st_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign prev = st_q.prev;
    assign have = st_q.have;
endmodule

// File: rtl/ltr_succ.sv
module ltr_succ
    import ltr_pkg::*;
(
    input  sym_t prev,
    input  logic have,
    input  sym_t sym,
    output logic is_step
);
    localparam sym_t ONE  = sym_t'(1);
    localparam sym_t LAST = '1;

    sym_t next_d;
    logic step_d;

    always_comb begin
        next_d = prev + ONE;
        step_d = have && (prev != LAST) && (sym == next_d);
    end

    assign is_step = step_d;
endmodule

// File: rtl/letter_step_detect.sv
module letter_step_detect
    import ltr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_in,
    output logic             hit
);
    sym_t prev_q;
    logic have_q;
    logic step_d;

    ltr_hist u_hist (
        .clk  (clk),
        .rst  (rst),
        .load (sym_valid),
        .sym  (sym_in),
        .prev (prev_q),
        .have (have_q)
    );

    ltr_succ u_succ (
        .prev    (prev_q),
        .have    (have_q),
        .sym     (sym_in),
        .is_step (step_d)
    );

    assign hit = !rst && sym_valid && step_d;
endmodule

// File: rtl/letter_step_detect_chk.sv
module letter_step_detect_chk
    import ltr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sym_valid,
    input logic [SYM_W-1:0] sym_in,
    input logic             hit
);
    sym_t seen_q;
    logic seen_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q    <= '0;
            seen_ok_q <= 1'b0;
        end else if (sym_valid) begin
            seen_q    <= sym_in;
            seen_ok_q <= 1'b1;
        end
    end

    AST_FIRST_QUIET: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && !seen_ok_q) |-> !hit); // R1
    AST_HIT_IS_STEP: assert property (@(posedge clk) disable iff (rst)
        hit |-> (seen_ok_q && sym_in == sym_t'(seen_q + sym_t'(1)))); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        hit |-> (sym_in != '0)); // R3
    AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && seen_ok_q && sym_in == seen_q) |-> !hit); // R4
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> !hit); // R6
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !hit); // R8
endmodule

bind letter_step_detect letter_step_detect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sym_valid (sym_valid),
    .sym_in    (sym_in),
    .hit       (hit)
);

// File: tb/letter_step_detect_bench.sv
`timescale 1ns/1ps
module letter_step_detect_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_in = 2'b00;
    logic       hit;

    int total = 0;
    int bad = 0;
    int m_prev = 0;
    bit m_have = 0;

    always #10 clk = ~clk;

    letter_step_detect u_letter_step_detect (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .sym_in    (sym_in),
        .hit       (hit)
    );

    task automatic step(input bit r, input bit v, input int s, input string tag);
        bit exp;
        @(negedge clk);
        rst       = r;
        sym_valid = v;
        sym_in    = 2'(s);
        #5;
        exp = !r && v && m_have && (m_prev != 3) && (s == m_prev + 1);
        total++;
        if (hit !== exp) begin
            bad++;
            $display("FAIL %s: r=%0b v=%0b sym=%0d hit=%0b expected=%0b",
                     tag, r, v, s, hit, exp);
        end
        @(posedge clk);
        if (r) begin
            m_have = 0;
            m_prev = 0;
        end else if (v) begin
            m_have = 1;
            m_prev = s;
        end
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(1, 0, 0, "R8 reset idle");
        step(1, 1, 1, "R8 reset with letter");
        step(0, 1, 1, "R1 first letter B");
        step(0, 1, 2, "R2 pair BC");
        step(0, 1, 3, "R2 pair CD");
        step(0, 1, 0, "R3 pair DA");
        step(0, 1, 1, "R2 pair AB");
        step(0, 1, 1, "R4 repeat BB");
        step(0, 1, 0, "R5 descending BA");
        step(0, 1, 2, "R5 skip AC");
        step(0, 1, 2, "R4 repeat CC");
        step(0, 0, 3, "R6 idle with D");
        step(0, 0, 0, "R6 idle with A");
        step(0, 1, 3, "R6 CD across idle");
        step(0, 1, 3, "R4 repeat DD");
        step(1, 0, 0, "R8 reset");
        step(0, 1, 0, "R1 first letter A");
        step(0, 1, 1, "R7 run AB");
        step(0, 1, 2, "R7 run BC");
        step(0, 1, 3, "R7 run CD");
        step(0, 1, 0, "R3 DA again");
        step(1, 1, 1, "R8 reset beats AB");
        step(0, 1, 2, "R8 C after reset");
        step(0, 1, 3, "R7 CD after reset");
        for (int i = 0; i < 3000; i++) begin
            int roll;
            roll = int'($urandom_range(0, 99));
            step(roll < 3, roll < 75, int'($urandom_range(0, 3)), "R2 R6 R7 random stream");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule